// File: doc/BRIEF.md
# Secure and Privileged Register Access Filter

This block sits on the access path between a register bus and a power-control register file. Each access carries a secure attribute and a privileged attribute. The filter decides, bit by bit, which bits of the addressed register the access may write and which it may read. A bit the access may not touch is handled silently: a write to it is dropped and a read of it returns zero. No error is raised.

The filter holds two configuration registers of its own. The security configuration has one bit per protectable item group: low-power mode, wake-up pins, voltage monitoring, battery mode and I/O pull configuration. The privilege configuration has a secure-privilege bit and a non-secure-privilege bit. A global trust enable input switches the security plane on and off. A parameter table gives the item group of every bit of every register-file register. A bit can also be left out of every group, and such a bit is always non-secure. A set of status registers can be marked so that they stay readable without privilege.

The filter is purely combinational on the access path. Only the two configuration registers are clocked.

Top module: `secpriv_access_filter`

## Requirements
- R1: After reset, the security configuration (address NREG) and the privilege configuration (address NREG+1) both read as zero, and every register-file bit is readable and writable by any access.
- R2: With trust enabled, a bit is secure when its group's bit is set in the security configuration (bit 0 low-power, 1 wake-up, 2 voltage monitor, 3 battery, 4 I/O pull). A non-secure access gets secure bits as zero on reads, and its writes to them are masked out per bit, so one write can partly succeed. The default table for register r places bits 15:0 in group r mod 5, bits 23:16 in group (r+1) mod 5, and leaves bits 31:24 ungrouped.
- R3: A secure access reaches both secure and non-secure bits, as long as the privilege rules allow it.
- R4: With trust disabled, the security configuration reads as zero and ignores writes, and every register-file bit is treated as non-secure. The stored security value is kept.
- R5: With trust enabled, only a secure access can write the security configuration, and any access can read it.
- R6: The privilege configuration can be read by any access. Unprivileged writes to it are dropped. Its bit 1 (non-secure privilege) takes any privileged write. Its bit 0 (secure privilege) takes only a secure privileged write.
- R7: With secure privilege set, secure bits need a privileged access for both read and write, and the security configuration needs a privileged access to be written. Both configuration registers stay readable without privilege.
- R8: With non-secure privilege set, non-secure bits need a privileged access, except that reads of the status registers (default addresses 4 and 5) are allowed unprivileged.
- R9: The filter decides within the same cycle. The register-file write strobe is raised only for a valid write to a register-file address that has at least one writable bit. Read data is zero when no valid read is presented.
- R10: A configuration write takes effect for the access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tz_enable | input | 1 | Global trust enable |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| acc_addr | input | AW | Register address (file, then security cfg, then privilege cfg) |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Filtered read data |
| rf_addr | output | RW | Register-file index |
| rf_wen | output | 1 | Register-file write strobe |
| rf_wmask | output | DW | Per-bit write enable to the register file |
| rf_wdata | output | DW | Write data to the register file |
| rf_rdata | input | DW | Raw register-file read data |

## Verification
The assertions assume that the raw register-file read data is always a defined value and that the trust enable and access attributes only change between clock edges. The bench holds the raw read data at all ones, so every read directly shows the filter's read mask. All inputs are driven on the falling edge, and configuration writes are always followed by a separate idle or read cycle. The properties that compare configuration state across an edge therefore see exactly one write attempt per edge.

// File: rtl/spaf_pkg.sv
// Package: shared constants, access-target type and the default
// bit-to-group table builder for the secure/privileged access filter.
// Assumes the group table fits in MAP_MAX bits.
package spaf_pkg;

    localparam int MAP_MAX       = 4096;
    localparam int GRP_LOWPWR    = 0;
    localparam int GRP_WAKEUP    = 1;
    localparam int GRP_VMON      = 2;
    localparam int GRP_BATT      = 3;
    localparam int GRP_IOPULL    = 4;
    localparam int PRIV_SEC_BIT  = 0;
    localparam int PRIV_NSEC_BIT = 1;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_FILE,
        TGT_SECCFG,
        TGT_PRIVCFG
    } acc_target_e;

    // Builds the default table: low half -> group r mod ngrp,
    // third quarter -> group (r+1) mod ngrp, top quarter -> ungrouped.
    function automatic logic [MAP_MAX-1:0] default_map(int nreg, int dw, int gw, int ngrp);
        logic [MAP_MAX-1:0] m;
        int code;
        int pos;
        m = '0;
        for (int r = 0; r < nreg; r++) begin
            for (int b = 0; b < dw; b++) begin
                if (b < dw / 2)
                    code = r % ngrp;
                else if (b < (dw * 3) / 4)
                    code = (r + 1) % ngrp;
                else
                    code = (1 << gw) - 1;
                for (int k = 0; k < gw; k++) begin
                    pos = (r * dw + b) * gw + k;
                    if (pos < MAP_MAX)
                        m[pos] = code[k];
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/spaf_decode.sv
// Address decoder: classifies an access address as register file,
// security configuration, privilege configuration or unused.
// Assumes the file occupies 0..NREG-1 and the two configuration
// registers follow it directly.
module spaf_decode #(
    parameter int NREG = 6,
    parameter int AW   = 3,
    parameter int RW   = 3
) (
    input  logic [AW-1:0]             addr,
    output spaf_pkg::acc_target_e     target,
    output logic [RW-1:0]             file_idx
);
    localparam logic [AW-1:0] SEC_A  = AW'(NREG);
    localparam logic [AW-1:0] PRIV_A = AW'(NREG + 1);

    // Classify address into its target.
    always_comb begin
        file_idx = addr[RW-1:0];
        if (addr < SEC_A)
            target = spaf_pkg::TGT_FILE;
        else if (addr == SEC_A)
            target = spaf_pkg::TGT_SECCFG;
        else if (addr == PRIV_A)
            target = spaf_pkg::TGT_PRIVCFG;
        else
            target = spaf_pkg::TGT_NONE;
    end
endmodule

// File: rtl/spaf_cfg_regs.sv
// Configuration registers: holds the per-group security bits and the
// two privilege bits, applying the write rules for each.
// Assumes wr_sec / wr_priv are single-cycle write strobes that are
// already qualified by valid, write and address.
module spaf_cfg_regs #(
    parameter int NGRP = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tz_enable,
    input  logic            wr_sec,
    input  logic            wr_priv,
    input  logic            acc_secure,
    input  logic            acc_priv,
    input  logic [NGRP-1:0] sec_wdata,
    input  logic [1:0]      priv_wdata,
    output logic [NGRP-1:0] sec_cfg_q,
    output logic            spriv_q,
    output logic            nspriv_q
);
    logic sec_ok;
    logic priv_any_ok;
    logic priv_sec_ok;

    // Write qualification for each configuration field.
    always_comb begin
        sec_ok      = wr_sec && tz_enable && acc_secure && (!spriv_q || acc_priv);
        priv_any_ok = wr_priv && acc_priv;
        priv_sec_ok = wr_priv && acc_priv && acc_secure;
    end

    // Security configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_cfg_q <= '0;
        else if (sec_ok)
            sec_cfg_q <= sec_wdata;
    end

    // Privilege configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spriv_q  <= 1'b0;
            nspriv_q <= 1'b0;
        end else begin
            if (priv_sec_ok)
                spriv_q <= priv_wdata[spaf_pkg::PRIV_SEC_BIT];
            if (priv_any_ok)
                nspriv_q <= priv_wdata[spaf_pkg::PRIV_NSEC_BIT];
        end
    end
endmodule

// File: rtl/spaf_bit_policy.sv
// Per-bit policy: for the addressed register-file entry, derives the
// read and write masks from the group table, the security and
// privilege configuration and the access attributes.
// Assumes file_idx is meaningful only for register-file accesses;
// out-of-range indices fall back to entry 0.
module spaf_bit_policy #(
    parameter int   NREG = 6,
    parameter int   DW   = 32,
    parameter int   NGRP = 5,
    parameter int   GW   = 3,
    parameter int   RW   = 3,
    parameter logic [NREG*DW*GW-1:0] MAP = '0
) (
    input  logic            tz_enable,
    input  logic [NGRP-1:0] sec_cfg,
    input  logic            spriv,
    input  logic            nspriv,
    input  logic            acc_secure,
    input  logic            acc_priv,
    input  logic [RW-1:0]   file_idx,
    input  logic            is_status,
    output logic [DW-1:0]   rd_mask,
    output logic [DW-1:0]   wr_mask
);
    localparam int ROWW = DW * GW;
    localparam int NCODE = 1 << GW;

    logic [ROWW-1:0]  row;
    logic [NCODE-1:0] sec_ext;

    // Select the table row of the addressed register and pad the group bits.
    always_comb begin
        sec_ext = '0;
        sec_ext[NGRP-1:0] = sec_cfg;
        if (int'(file_idx) < NREG)
            row = MAP[int'(file_idx) * ROWW +: ROWW];
        else
            row = MAP[0 +: ROWW];
    end

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic [GW-1:0] code;
        logic          sec_bit;
        logic          need_pw;
        logic          need_pr;
        logic          dom_ok;

        // Resolve the security and privilege planes for this bit.
        always_comb begin
            code    = row[b*GW +: GW];
            sec_bit = tz_enable && (int'(code) < NGRP) && sec_ext[code];
            need_pw = sec_bit ? spriv : nspriv;
            need_pr = sec_bit ? spriv : (nspriv && !is_status);
            dom_ok  = !sec_bit || acc_secure;
            wr_mask[b] = dom_ok && (!need_pw || acc_priv);
            rd_mask[b] = dom_ok && (!need_pr || acc_priv);
        end
    end
endmodule

// File: rtl/secpriv_access_filter.sv
// Top: secure/privileged access filter in front of a power-control
// register file. Passes permitted write bits through a per-bit mask,
// zeroes forbidden read bits, and serves the two configuration
// registers locally. Assumes one access per cycle and that the
// register file applies rf_wmask bit by bit.
module secpriv_access_filter #(
    parameter int NREG = 6,
    parameter int DW   = 32,
    parameter int NGRP = 5,
    parameter logic [NREG-1:0] STATUS_REGS = 6'b110000,
    parameter bit USE_DEFAULT_MAP = 1'b1,
    parameter logic [NREG*DW*$clog2(NGRP+1)-1:0] GRP_MAP = '0,
    localparam int AW = $clog2(NREG + 2),
    localparam int RW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tz_enable,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          acc_secure,
    input  logic          acc_priv,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    output logic [RW-1:0] rf_addr,
    output logic          rf_wen,
    output logic [DW-1:0] rf_wmask,
    output logic [DW-1:0] rf_wdata,
    input  logic [DW-1:0] rf_rdata
);
    localparam int GW   = $clog2(NGRP + 1);
    localparam int MAPW = NREG * DW * GW;
    localparam logic [spaf_pkg::MAP_MAX-1:0] FULL_MAP =
        spaf_pkg::default_map(NREG, DW, GW, NGRP);
    localparam logic [MAPW-1:0] MAP = USE_DEFAULT_MAP ? FULL_MAP[MAPW-1:0] : GRP_MAP;

    spaf_pkg::acc_target_e target;
    logic [RW-1:0]   file_idx;
    logic [NGRP-1:0] sec_cfg_q;
    logic            spriv_q;
    logic            nspriv_q;
    logic [DW-1:0]   rd_mask;
    logic [DW-1:0]   wr_mask;
    logic            is_status;
    logic            wr_acc;
    logic            rd_acc;

    spaf_decode #(.NREG(NREG), .AW(AW), .RW(RW)) u_dec (
        .addr     (acc_addr),
        .target   (target),
        .file_idx (file_idx)
    );

    // Qualify access direction and the status-register flag.
    always_comb begin
        wr_acc    = acc_valid && acc_write;
        rd_acc    = acc_valid && !acc_write;
        is_status = (int'(file_idx) < NREG) ? STATUS_REGS[file_idx] : 1'b0;
    end

    spaf_cfg_regs #(.NGRP(NGRP)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .tz_enable  (tz_enable),
        .wr_sec     (wr_acc && (target == spaf_pkg::TGT_SECCFG)),
        .wr_priv    (wr_acc && (target == spaf_pkg::TGT_PRIVCFG)),
        .acc_secure (acc_secure),
        .acc_priv   (acc_priv),
        .sec_wdata  (acc_wdata[NGRP-1:0]),
        .priv_wdata (acc_wdata[1:0]),
        .sec_cfg_q  (sec_cfg_q),
        .spriv_q    (spriv_q),
        .nspriv_q   (nspriv_q)
    );

    spaf_bit_policy #(
        .NREG(NREG), .DW(DW), .NGRP(NGRP), .GW(GW), .RW(RW), .MAP(MAP)
    ) u_pol (
        .tz_enable  (tz_enable),
        .sec_cfg    (sec_cfg_q),
        .spriv      (spriv_q),
        .nspriv     (nspriv_q),
        .acc_secure (acc_secure),
        .acc_priv   (acc_priv),
        .file_idx   (file_idx),
        .is_status  (is_status),
        .rd_mask    (rd_mask),
        .wr_mask    (wr_mask)
    );

    // Register-file write path: masked, same cycle.
    always_comb begin
        rf_addr  = file_idx;
        rf_wdata = acc_wdata;
        rf_wmask = (wr_acc && target == spaf_pkg::TGT_FILE) ? wr_mask : '0;
        rf_wen   = |rf_wmask;
    end

    // Read return mux with read-as-zero filtering.
    always_comb begin
        acc_rdata = '0;
        if (rd_acc) begin
            unique case (target)
                spaf_pkg::TGT_FILE:    acc_rdata = rf_rdata & rd_mask;
                spaf_pkg::TGT_SECCFG:  if (tz_enable) acc_rdata[NGRP-1:0] = sec_cfg_q;
                spaf_pkg::TGT_PRIVCFG: begin
                    acc_rdata[spaf_pkg::PRIV_SEC_BIT]  = spriv_q;
                    acc_rdata[spaf_pkg::PRIV_NSEC_BIT] = nspriv_q;
                end
                default:               acc_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spaf_checker.sv
// Checker: temporal properties of the access filter, bound to the top.
// Assumes rf_rdata is never X and inputs change only between edges.
module spaf_checker #(
    parameter int NREG = 6,
    parameter int DW   = 32,
    parameter int NGRP = 5,
    parameter int AW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tz_enable,
    input logic            acc_valid,
    input logic            acc_write,
    input logic            acc_secure,
    input logic            acc_priv,
    input logic [AW-1:0]   acc_addr,
    input logic [DW-1:0]   acc_rdata,
    input logic [DW-1:0]   rf_rdata,
    input logic            rf_wen,
    input logic [NGRP-1:0] sec_cfg_q,
    input logic            spriv_q,
    input logic            nspriv_q
);
    localparam logic [AW-1:0] SEC_A  = AW'(NREG);
    localparam logic [AW-1:0] PRIV_A = AW'(NREG + 1);

    p_tzoff_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tz_enable |=> $stable(sec_cfg_q));

    p_tzoff_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !tz_enable && acc_addr == SEC_A) |-> (acc_rdata == '0));

    p_sec_wr_nonsec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_secure && acc_addr == SEC_A) |=> $stable(sec_cfg_q));

    p_priv_unpriv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_priv && acc_addr == PRIV_A)
        |=> ($stable(spriv_q) && $stable(nspriv_q)));

    p_spriv_nonsec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_secure && acc_addr == PRIV_A) |=> $stable(spriv_q));

    p_rd_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr < SEC_A) |-> ((acc_rdata & ~rf_rdata) == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!rf_wen && acc_rdata == '0));

    p_wen_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wen |-> (acc_valid && acc_write && acc_addr < SEC_A));
endmodule

bind secpriv_access_filter spaf_checker #(
    .NREG(NREG), .DW(DW), .NGRP(NGRP), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tz_enable  (tz_enable),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_secure (acc_secure),
    .acc_priv   (acc_priv),
    .acc_addr   (acc_addr),
    .acc_rdata  (acc_rdata),
    .rf_rdata   (rf_rdata),
    .rf_wen     (rf_wen),
    .sec_cfg_q  (sec_cfg_q),
    .spriv_q    (spriv_q),
    .nspriv_q   (nspriv_q)
);

// File: tb/secpriv_access_filter_test.sv
`timescale 1ns/1ps
module secpriv_access_filter_test;
    localparam int NREG = 6;
    localparam int DW   = 32;
    localparam int AW   = 3;
    localparam int RW   = 3;
    localparam logic [AW-1:0] SEC_A  = 3'd6;
    localparam logic [AW-1:0] PRIV_A = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tz_enable = 1'b1;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic          acc_secure = 1'b0;
    logic          acc_priv = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] acc_rdata;
    logic [RW-1:0] rf_addr;
    logic          rf_wen;
    logic [DW-1:0] rf_wmask;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rf_rdata = '1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    secpriv_access_filter uut (
        .clk(clk), .rst_n(rst_n), .tz_enable(tz_enable),
        .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_secure(acc_secure), .acc_priv(acc_priv),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .rf_addr(rf_addr), .rf_wen(rf_wen), .rf_wmask(rf_wmask),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        #1;
    endtask

    task automatic do_write(input logic s, input logic p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_secure = s; acc_priv = p;
        acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic s, input logic p, input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_secure = s; acc_priv = p; acc_addr = a;
        #1;
        v = acc_rdata;
    endtask

    task automatic wr_probe(input logic s, input logic p, input logic [AW-1:0] a,
                            output logic [DW-1:0] m, output logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_secure = s; acc_priv = p;
        acc_addr = a; acc_wdata = 32'hA5A5_5A5A;
        #1;
        m = rf_wmask;
        w = rf_wen;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(1, 1, SEC_A, v);  chk("R1 sec cfg reset", v, 0);
        rd(1, 1, PRIV_A, v); chk("R1 priv cfg reset", v, 0);
        rd(0, 0, 3'd0, v);   chk("R1 open file read", v, 32'hFFFF_FFFF);
        idle();
    endtask

    task automatic t_trust_off();
        logic [DW-1:0] v;
        tz_enable = 1'b0;
        do_write(1, 1, SEC_A, 32'h1F);
        rd(1, 1, SEC_A, v);  chk("R4 sec cfg reads zero when off", v, 0);
        tz_enable = 1'b1;
        rd(1, 1, SEC_A, v);  chk("R4 write ignored when off", v, 0);
        idle();
    endtask

    task automatic t_security();
        logic [DW-1:0] v;
        logic [DW-1:0] m;
        logic w;
        do_write(0, 1, SEC_A, 32'h1);
        rd(1, 1, SEC_A, v);  chk("R5 non-secure write dropped", v, 0);
        do_write(1, 1, SEC_A, 32'h1);
        rd(0, 0, SEC_A, v);  chk("R5 readable by any", v, 32'h1);
        rd(0, 1, 3'd0, v);   chk("R2 reg0 non-secure read", v, 32'hFFFF_0000);
        wr_probe(0, 1, 3'd4, m, w);
        chk("R2 reg4 partial write mask", m, 32'hFF00_FFFF);
        chk("R2 reg4 write strobe", {31'd0, w}, 1);
        rd(1, 1, 3'd0, v);   chk("R3 secure read all", v, 32'hFFFF_FFFF);
        wr_probe(1, 0, 3'd0, m, w);
        chk("R3 secure write all", m, 32'hFFFF_FFFF);
        tz_enable = 1'b0;
        rd(0, 0, 3'd0, v);   chk("R4 all non-secure when off", v, 32'hFFFF_FFFF);
        rd(1, 1, SEC_A, v);  chk("R4 sec cfg zero when off", v, 0);
        tz_enable = 1'b1;
        rd(1, 1, SEC_A, v);  chk("R4 stored value kept", v, 32'h1);
        idle();
    endtask

    task automatic t_next_cycle();
        logic [DW-1:0] v;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_secure = 1; acc_priv = 1;
        acc_addr = SEC_A; acc_wdata = 32'h3;
        rd(0, 1, 3'd1, v);   chk("R10 new cfg used next cycle", v, 32'hFFFF_0000);
        idle();
    endtask

    task automatic t_privcfg();
        logic [DW-1:0] v;
        do_write(0, 0, PRIV_A, 32'h3);
        rd(1, 1, PRIV_A, v); chk("R6 unprivileged write dropped", v, 0);
        do_write(0, 1, PRIV_A, 32'h3);
        rd(1, 1, PRIV_A, v); chk("R6 non-secure privileged sets bit1 only", v, 32'h2);
        do_write(1, 1, PRIV_A, 32'h1);
        rd(0, 0, PRIV_A, v); chk("R6 secure privileged write, any read", v, 32'h1);
        idle();
    endtask

    task automatic t_spriv();
        logic [DW-1:0] v;
        do_write(1, 1, SEC_A, 32'h1);
        rd(1, 0, 3'd0, v);   chk("R7 secure unprivileged read", v, 32'hFFFF_0000);
        rd(1, 1, 3'd0, v);   chk("R7 secure privileged read", v, 32'hFFFF_FFFF);
        rd(1, 0, SEC_A, v);  chk("R7 sec cfg readable unprivileged", v, 32'h1);
        do_write(1, 0, SEC_A, 32'h0);
        rd(1, 1, SEC_A, v);  chk("R7 sec cfg needs privileged write", v, 32'h1);
        rd(0, 0, 3'd0, v);   chk("R7 non-secure bits unaffected", v, 32'hFFFF_0000);
        idle();
    endtask

    task automatic t_nspriv();
        logic [DW-1:0] v;
        logic [DW-1:0] m;
        logic w;
        do_write(1, 1, PRIV_A, 32'h2);
        rd(0, 0, 3'd1, v);   chk("R8 unprivileged read blocked", v, 0);
        rd(0, 1, 3'd1, v);   chk("R8 privileged read", v, 32'hFFFF_FFFF);
        rd(0, 0, 3'd4, v);   chk("R8 status reg readable", v, 32'hFF00_FFFF);
        wr_probe(0, 0, 3'd4, m, w);
        chk("R8 status reg unprivileged write mask", m, 0);
        chk("R9 no strobe on empty mask", {31'd0, w}, 0);
        rd(1, 0, 3'd0, v);   chk("R8 secure unprivileged mix", v, 32'h0000_FFFF);
        idle();
    endtask

    task automatic t_idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 3'd2;
        #1;
        chk("R9 idle read data", acc_rdata, 0);
        chk("R9 idle write strobe", {31'd0, rf_wen}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_trust_off();
        t_security();
        t_next_cycle();
        t_privcfg();
        t_spriv();
        t_nspriv();
        t_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule